// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A load pulse captures a full starting address. After that, every cycle in which the active-low advance strobe is sampled low moves the burst one beat forward. The low two address bits follow the beat sequence. The upper bits stay at the captured value for the whole burst.

Two beat orders are available. In linear order the low bits count up from the start and wrap within the group of four. In interleaved order the low bits are the start bits XOR the beat number. The order select is a strap: it is expected to stay fixed while bursts run. It should be tied high for interleaved order, which is also the intended default when the pin is left undriven.

Both outputs come from registers plus a small mapping stage. A load or advance sampled at one rising edge is therefore visible right after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the beat index and all address bits return to zero.
- R2: A `load` sampled high captures `start_addr`. After that edge, `addr_out` equals `start_addr` and `beat` is 0.
- R3: When `load` and an active advance (`adv_n` low) are sampled in the same cycle, the load wins. The beat index becomes 0, not 1.
- R4: With `load` low and `adv_n` high, both `addr_out` and `beat` keep their values.
- R5: With `load` low and `adv_n` low, `beat` increases by one modulo 4.
- R6: With `order_sel` = 0 (linear), `addr_out[1:0]` equals (start low bits + beat) mod 4.
- R7: With `order_sel` = 1 (interleaved), `addr_out[1:0]` equals the start low bits XOR beat.
- R8: `addr_out[ADDR_W-1:2]` always equals the upper bits of the last captured start address. Advances never change it.
- R9: After four advances, the burst wraps back to the starting address with beat 0. A fifth advance repeats the second beat's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture `start_addr` and begin a burst |
| start_addr | input | ADDR_W | First address of the burst |
| adv_n | input | 1 | Advance strobe, active low |
| order_sel | input | 1 | Static order strap: 0 selects linear, 1 selects interleaved |
| addr_out | output | ADDR_W | Address for the current beat |
| beat | output | 2 | Index of the current beat, 0 to 3 |

## Verification
The checker assumes `order_sel` is a true strap. Its per-step properties for the linear and interleaved cases compare each beat with the one before under the current order value, so a change of `order_sel` in the middle of a burst would break them. The bench sets `order_sel` only while `rst` is held and then resets again, so every burst runs under a single order. The bench holds reset for several cycles, so the first `$past` sample taken after release already sees reset values.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        beat_t start_low;
        beat_t beat;
    } burst_pos_t;

    function automatic beat_t order_map(order_e ord, beat_t s, beat_t n);
        beat_t r;
        if (ord == ORD_LINEAR) r = s + n;
        else                   r = s ^ n;
        return r;
    endfunction

endpackage

// File: rtl/burst_capture_reg.sv
module burst_capture_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int UP_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [UP_W-1:0]   upper_q,
    output burst_pos_t        pos_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            pos_q   <= '0;
        end else if (load) begin
            upper_q         <= start_addr[ADDR_W-1:BEAT_W];
            pos_q.start_low <= start_addr[BEAT_W-1:0];
            pos_q.beat      <= '0;
        end else if (!adv_n) begin
            pos_q.beat <= pos_q.beat + beat_t'(1);
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  logic       order_sel,
    input  burst_pos_t pos,
    output beat_t      low_addr
);

    order_e ord;

    always_comb begin
        ord      = order_e'(order_sel);
        low_addr = order_map(ord, pos.start_low, pos.beat);
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat
);

    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0] upper_q;
    burst_pos_t      pos_q;
    beat_t           low_addr;

    burst_capture_reg #(.ADDR_W(ADDR_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .adv_n      (adv_n),
        .start_addr (start_addr),
        .upper_q    (upper_q),
        .pos_q      (pos_q)
    );

    burst_order_map u_map (
        .order_sel (order_sel),
        .pos       (pos_q),
        .low_addr  (low_addr)
    );

    assign addr_out = {upper_q, low_addr};
    assign beat     = pos_q.beat;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [ADDR_W-1:0] start_addr,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat
);

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load |=> (addr_out == $past(start_addr) && beat == 2'd0)); // R2

    AST_LOAD_OVER_ADV: assert property (@(posedge clk) disable iff (rst)
        (load && !adv_n) |=> beat == 2'd0); // R3

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && adv_n) |=> ($stable(addr_out) && $stable(beat))); // R4

    AST_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv_n) |=> beat == $past(beat) + 2'd1); // R5

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!order_sel && !load && !adv_n) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1); // R6

    AST_INTERLEAVE_KEY: assert property (@(posedge clk) disable iff (rst)
        (order_sel && !load) |=> (addr_out[1:0] ^ beat) == $past(addr_out[1:0] ^ beat)); // R7

    AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])); // R8

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              adv_n = 1'b1;
    logic              order_sel = 1'b1;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0]        beat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
        .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
        .adv_n(adv_n), .order_sel(order_sel), .addr_out(addr_out), .beat(beat)
    );

    function automatic logic [ADDR_W-1:0] expect_addr(logic [ADDR_W-1:0] s, logic [1:0] n, logic ord);
        logic [1:0] lo;
        lo = ord ? (s[1:0] ^ n) : (s[1:0] + n);
        return {s[ADDR_W-1:2], lo};
    endfunction

    task automatic check(string tag, logic [ADDR_W-1:0] ea, logic [1:0] eb);
        checks++;
        if (addr_out !== ea || beat !== eb) begin
            fails++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d", tag, addr_out, beat, ea, eb);
        end
    endtask

    task automatic cycle(logic ld, logic [ADDR_W-1:0] a, logic an);
        load = ld; start_addr = a; adv_n = an;
        @(posedge clk); #1;
        load = 1'b0; adv_n = 1'b1;
    endtask

    task automatic do_reset(logic ord);
        rst = 1'b1; order_sel = ord;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", '0, 2'd0);
        rst = 1'b0;
    endtask

    task automatic t_burst(string tag, logic [ADDR_W-1:0] s, logic ord);
        cycle(1'b1, s, 1'b1);
        check({tag, " R2 load"}, s, 2'd0);
        for (int i = 1; i <= 5; i++) begin
            cycle(1'b0, 8'h00, 1'b0);
            check({tag, ord ? " R7 R8 R9 step" : " R6 R8 R9 step"}, expect_addr(s, 2'(i), ord), 2'(i));
        end
    endtask

    task automatic t_hold(logic [ADDR_W-1:0] s, logic ord);
        cycle(1'b1, s, 1'b1);
        cycle(1'b0, 8'h00, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 8'hFF, 1'b1);
            check("R4 hold", expect_addr(s, 2'd1, ord), 2'd1);
        end
    endtask

    task automatic t_priority(logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] s2);
        cycle(1'b1, s, 1'b1);
        cycle(1'b0, 8'h00, 1'b0);
        cycle(1'b1, s2, 1'b0);
        check("R3 load beats advance", s2, 2'd0);
        cycle(1'b0, 8'h00, 1'b0);
        check("R5 step after load", expect_addr(s2, 2'd1, order_sel), 2'd1);
    endtask

    initial begin
        do_reset(1'b0);
        t_burst("linear", 8'h4E, 1'b0);
        t_burst("linear", 8'hB1, 1'b0);
        t_hold(8'h23, 1'b0);
        t_priority(8'h12, 8'hC7);
        do_reset(1'b1);
        t_burst("interleave", 8'h49, 1'b1);
        t_burst("interleave", 8'hF2, 1'b1);
        t_hold(8'h6B, 1'b1);
        t_priority(8'h3D, 8'h80);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule